// File: doc/BRIEF.md
# SPI Master Controller with Status Interlock

This block is a byte-wide serial peripheral interface master behind a small register bus. A write to the data register starts a full-duplex exchange: eight bits leave on `mosi_o`, most significant first, while eight bits arrive from `miso_i`. The serial clock comes from the system clock, counted only on cycles where `clk_en_i` is high, through a three-bit rate select whose divide table is deliberately non-monotonic. Clock polarity and phase choose which SCK edge samples and which one shifts.

A status register reports completion, write collision and mode fault. The completion flag drives the interrupt when interrupts are enabled. Flags clear by a two-step handshake: first a status read that sees a flag set, then any access to the data register. Until that status read has happened, data writes after a completed transfer are dropped. This keeps software from overwriting a byte it has not yet acknowledged.

Register map (two-bit address): 0 = control, 1 = status, 2 = data, 3 = option. Control bits: [7] interrupt enable, [6] master enable, [3] clock polarity, [2] clock phase, [1:0] low rate-select bits. Option bit [0] is the high rate-select bit.

Top module: `spi_master_ctl`

## Requirements
- R1: Rate select {option[0], control[1:0]} gives an SCK period of 2, 4, 16, 32, 8, 16, 64 or 128 enabled clocks for codes 0 to 7. The interrupt (with enable set) rises exactly 8 × period enabled clocks after the clock edge that takes the starting data write.
- R2: The option register resets to 0x00, so after reset the divide ratio depends on control[1:0] alone.
- R3: Bytes go out MSB first. With phase 0, MISO is sampled on the leading SCK edge; with phase 1, on the trailing edge. MOSI changes only on the non-sampling edge. When the transfer completes, the received byte is loaded into the data read buffer.
- R4: SCK sits at the polarity level whenever no transfer is running.
- R5: Status reads as bit7 = complete, bit6 = collision, bit4 = mode fault, all other bits 0, and it resets to 0x00.
- R6: The complete flag sets when the eighth bit ends. The interrupt output equals complete AND interrupt enable.
- R7: Complete and collision clear only on a data read or write that follows a status read which saw either flag set. A data write in that position also starts a new transfer.
- R8: While complete is set and no qualifying status read has happened, a data write is ignored. No SCK activity results, and neither the flags nor the read buffer change.
- R9: A data write during a transfer leaves the byte on the wire unchanged and sets collision. Collision clears through the R7 sequence.
- R10: While master enable is set, a mode-fault input sets the fault flag, stops the transfer with SCK back at idle, and clears master enable. The fault flag clears on a control write that follows a status read which saw it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Qualifies clocks counted by the rate divider |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| mode_fault_i | input | 1 | Mode-fault request from the bus |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The main exchange is swept across all eight rate codes and all four polarity/phase combinations, each with two byte pairs. The transfer length tells the divide entries apart, including the repeated ratio of 16 and the out-of-order ratio of 8. Received bytes at both ends tell the sampling edges apart, and the idle level shows polarity. Separate sequences cover four cases: a write with no prior status read, a write during a transfer, an aborted transfer, and a transfer with interrupts masked. Each of these shows at the ports whether the interlock either dropped or accepted the access.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 7;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_OPT  = 2'd3
  } reg_addr_e;

  // half SCK period in enabled clocks; table is non-monotonic on purpose
  function automatic logic [CNT_W-1:0] half_period(input logic [2:0] sel);
    case (sel)
      3'd0:    half_period = CNT_W'(1);
      3'd1:    half_period = CNT_W'(2);
      3'd2:    half_period = CNT_W'(8);
      3'd3:    half_period = CNT_W'(16);
      3'd4:    half_period = CNT_W'(4);
      3'd5:    half_period = CNT_W'(8);
      3'd6:    half_period = CNT_W'(32);
      default: half_period = CNT_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int CW = spim_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          en_i,
  input  logic [CW-1:0] half_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;

  // >= keeps the divider live if the rate shrinks mid-count
  assign tick_o = run_i & en_i & (cnt_q >= half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $stable(half_i) && cnt_q < half_i) |=> (cnt_q < half_i));

  assert_cnt_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW = spim_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] data_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          sck_o,
  output logic          mosi_o
);
  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

  logic          busy_q, phase_q, mosi_q;
  logic [EW-1:0] edge_q;
  logic [DW-1:0] tx_q, rx_q;
  logic          leading, sample, shift;

  assign leading = ~phase_q;
  assign sample  = tick_i & (leading ^ cpha_i);
  assign shift   = tick_i & ~(leading ^ cpha_i);
  assign done_o  = busy_q & tick_i & (edge_q == LAST_EDGE);
  assign rx_o    = sample ? {rx_q[DW-2:0], miso_i} : rx_q;
  assign busy_o  = busy_q;
  assign sck_o   = cpol_i ^ phase_q;
  assign mosi_o  = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; phase_q <= 1'b0; mosi_q <= 1'b0;
      edge_q <= '0;   tx_q    <= '0;   rx_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0; phase_q <= 1'b0; edge_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      edge_q  <= '0;
      tx_q    <= data_i;
      mosi_q  <= data_i[DW-1];
      rx_q    <= '0;
    end else if (tick_i) begin
      phase_q <= ~phase_q;
      edge_q  <= edge_q + 1'b1;
      rx_q    <= rx_o;
      if (done_o) busy_q <= 1'b0;
      if (shift) begin
        // phase 1 presents the next bit on the leading edge, phase 0 on the trailing
        mosi_q <= cpha_i ? tx_q[DW-1] : tx_q[DW-2];
        tx_q   <= {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (sck_o == cpol_i));

  assert_done_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);

  assert_mosi_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && !abort_i && !shift) |=> $stable(mosi_q));
endmodule

// File: rtl/spim_status.sv
module spim_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic ctrl_wr_i,
  input  logic done_i,
  input  logic col_i,
  input  logic fault_i,
  output logic spif_o,
  output logic wcol_o,
  output logic modf_o,
  output logic wr_block_o
);
  logic spif_q, wcol_q, modf_q, arm_q, modf_arm_q, clr;

  assign clr        = data_acc_i & arm_q;
  assign spif_o     = spif_q;
  assign wcol_o     = wcol_q;
  assign modf_o     = modf_q;
  assign wr_block_o = spif_q & ~arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spif_q <= 1'b0; wcol_q <= 1'b0; modf_q <= 1'b0;
      arm_q  <= 1'b0; modf_arm_q <= 1'b0;
    end else begin
      if (done_i)      spif_q <= 1'b1;
      else if (clr)    spif_q <= 1'b0;
      if (col_i)       wcol_q <= 1'b1;
      else if (clr)    wcol_q <= 1'b0;
      if (data_acc_i)                      arm_q <= 1'b0;
      else if (stat_rd_i && (spif_q || wcol_q)) arm_q <= 1'b1;
      if (fault_i)                         modf_q <= 1'b1;
      else if (ctrl_wr_i && modf_arm_q)    modf_q <= 1'b0;
      if (ctrl_wr_i)                       modf_arm_q <= 1'b0;
      else if (stat_rd_i && modf_q)        modf_arm_q <= 1'b1;
    end
  end

  assert_spif_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> spif_q);

  assert_spif_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && arm_q && !done_i) |=> !spif_q);

  assert_spif_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spif_q && !arm_q) |=> spif_q);

  assert_wcol_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_i |=> wcol_q);
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl #(
  parameter int DW = spim_pkg::DATA_W,
  parameter int CW = spim_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clk_en_i,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          mode_fault_i,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          irq_o
);
  import spim_pkg::*;

  logic          ien_q, men_q, cpol_q, cpha_q, rate_hi_q;
  logic [1:0]    rate_lo_q;
  logic [DW-1:0] rbuf_q, rx;
  logic          wr, rd, wr_ctrl, wr_opt, wr_data, rd_stat, data_acc;
  logic          fault_evt, start, col_evt, busy, done, tick;
  logic          spif, wcol, modf, wr_block;
  logic [CW-1:0] half;

  assign wr        = cs_i & we_i;
  assign rd        = cs_i & ~we_i;
  assign wr_ctrl   = wr & (addr_i == A_CTRL);
  assign wr_opt    = wr & (addr_i == A_OPT);
  assign wr_data   = wr & (addr_i == A_DATA);
  assign rd_stat   = rd & (addr_i == A_STAT);
  assign data_acc  = cs_i & (addr_i == A_DATA);
  assign fault_evt = mode_fault_i & men_q;
  assign start     = wr_data & men_q & ~busy & ~wr_block & ~fault_evt;
  assign col_evt   = wr_data & busy & ~wr_block & ~fault_evt;
  assign half      = CW'(half_period({rate_hi_q, rate_lo_q}));
  assign irq_o     = spif & ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= 1'b0; men_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      rate_lo_q <= '0; rate_hi_q <= 1'b0; rbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ien_q     <= wdata_i[7];
        men_q     <= wdata_i[6] & ~fault_evt;
        cpol_q    <= wdata_i[3];
        cpha_q    <= wdata_i[2];
        rate_lo_q <= wdata_i[1:0];
      end else if (fault_evt) begin
        men_q <= 1'b0;
      end
      if (wr_opt) rate_hi_q <= wdata_i[0];
      if (done)   rbuf_q    <= rx;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[7:0] = {ien_q, men_q, 2'b00, cpol_q, cpha_q, rate_lo_q};
      A_STAT: rdata_o[7:0] = {spif, wcol, 1'b0, modf, 4'b0000};
      A_DATA: rdata_o      = rbuf_q;
      default: rdata_o[0]  = rate_hi_q;
    endcase
  end

  spim_clkdiv #(.CW(CW)) i_clkdiv (
    .clk_i, .rst_ni, .run_i(busy), .en_i(clk_en_i), .half_i(half), .tick_o(tick)
  );

  spim_shift #(.DW(DW)) i_shift (
    .clk_i, .rst_ni, .start_i(start), .abort_i(fault_evt), .data_i(wdata_i),
    .cpol_i(cpol_q), .cpha_i(cpha_q), .tick_i(tick), .miso_i,
    .busy_o(busy), .done_o(done), .rx_o(rx), .sck_o, .mosi_o
  );

  spim_status i_status (
    .clk_i, .rst_ni, .stat_rd_i(rd_stat), .data_acc_i(data_acc),
    .ctrl_wr_i(wr_ctrl), .done_i(done), .col_i(col_evt), .fault_i(fault_evt),
    .spif_o(spif), .wcol_o(wcol), .modf_o(modf), .wr_block_o(wr_block)
  );

  assert_blocked_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && wr_block && !busy) |=> !busy);

  assert_fault_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt |=> (!men_q && !busy && modf));

  assert_col_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && busy && !fault_evt && !done) |=> busy);
endmodule

// File: tb/test_spi_master_ctl.sv
`timescale 1ns/1ps
module test_spi_master_ctl;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, we = 1'b0, mf = 1'b0, miso = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sck, mosi, irq;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  spi_master_ctl i_spi_master_ctl (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(1'b1), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .mode_fault_i(mf),
    .miso_i(miso), .sck_o(sck), .mosi_o(mosi), .irq_o(irq)
  );

  // slave model
  logic s_en = 0, s_cpol = 0, s_cpha = 0;
  logic [7:0] s_tx = '0, s_rx = '0;
  int s_cnt = 0;
  always @(sck) if (s_en) begin
    if ((sck != s_cpol) ^ s_cpha) begin s_rx = {s_rx[6:0], mosi}; s_cnt++; end
    else if (s_cpha) begin miso = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
    else begin s_tx = {s_tx[6:0], 1'b0}; miso = s_tx[7]; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a; #1 d = rdata;
    @(posedge clk); #1 cs = 0;
  endtask

  task automatic slave_prep(input logic [7:0] b, input logic p, input logic h);
    s_tx = b; miso = b[7]; s_rx = '0; s_cnt = 0; s_cpol = p; s_cpha = h; s_en = 1;
  endtask

  function automatic int ratio(input int c);
    case (c)
      0: return 2;   1: return 4;  2: return 16; 3: return 32;
      4: return 8;   5: return 16; 6: return 64; default: return 128;
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  logic [7:0] v;

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #45 rst_n = 1;
    #1;
    // reset state
    rd(2'd1, v); chk(v == 8'h00, "R5 status reset", v, 0);
    rd(2'd3, v); chk(v == 8'h00, "R2 option reset", v, 0);
    rd(2'd0, v); chk(v == 8'h00, "R2 control reset", v, 0);
    chk(sck == 1'b0 && irq == 1'b0, "R4 idle after reset", {sck, irq}, 0);

    // sweep: rate x mode x pattern
    for (int r = 0; r < 8; r++) begin
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 2; p++) begin
          logic pol, pha;
          logic [7:0] mtx, stx;
          int n;
          pol = m[1]; pha = m[0];
          mtx = 8'(8'hA5 ^ (r * 37 + m * 11 + p * 92));
          stx = 8'(8'h3C ^ (r * 53 + m * 29 + p * 201));
          wr(2'd3, {7'b0, r[2]});
          wr(2'd0, {1'b1, 1'b1, 2'b00, pol, pha, r[1:0]});
          chk(sck == pol, "R4 idle level", sck, pol);
          slave_prep(stx, pol, pha);
          wr(2'd2, mtx);
          n = 0;
          while (!irq && n < 2000) begin @(posedge clk); #1 n++; end
          chk(n == 8 * ratio(r), "R1 transfer length", n, 8 * ratio(r));
          chk(s_rx == mtx && s_cnt == 8, "R3 slave received", s_rx, mtx);
          chk(sck == pol, "R4 idle after transfer", sck, pol);
          rd(2'd1, v); chk(v == 8'h80, "R6 status after transfer", v, 8'h80);
          rd(2'd2, v); chk(v == stx, "R3 read buffer", v, stx);
          rd(2'd1, v); chk(v == 8'h00 && irq == 0, "R7 cleared", v, 0);
          s_en = 0;
        end
      end
    end

    // R8: write without prior status read is dropped
    wr(2'd3, 8'h00);
    wr(2'd0, 8'hC0);
    slave_prep(8'h96, 0, 0);
    wr(2'd2, 8'h11);
    wait_cyc(20);
    chk(irq == 1, "R6 irq after fast transfer", irq, 1);
    slave_prep(8'h00, 0, 0);
    wr(2'd2, 8'h77);
    wait_cyc(30);
    chk(s_cnt == 0 && sck == 0, "R8 blocked write no clocks", s_cnt, 0);
    rd(2'd1, v); chk(v == 8'h80, "R8 flags unchanged", v, 8'h80);
    rd(2'd2, v); chk(v == 8'h96, "R8 buffer unchanged", v, 8'h96);
    rd(2'd1, v); chk(v == 8'h00, "R7 cleared by data read", v, 0);

    // R7: status read then data write clears and starts
    slave_prep(8'h5A, 0, 0);
    wr(2'd2, 8'hC3);
    wait_cyc(20);
    rd(2'd1, v); chk(v == 8'h80, "R7 status saw flag", v, 8'h80);
    slave_prep(8'hE1, 0, 0);
    wr(2'd2, 8'h3E);
    #1 chk(irq == 0, "R7 write clears flag", irq, 0);
    wait_cyc(20);
    chk(s_rx == 8'h3E && irq == 1, "R7 write after status read starts", s_rx, 8'h3E);
    rd(2'd1, v); rd(2'd2, v); chk(v == 8'hE1, "R7 second byte", v, 8'hE1);

    // R9: write collision
    wr(2'd0, 8'hC1);
    slave_prep(8'h24, 0, 0);
    wr(2'd2, 8'hB7);
    wait_cyc(5);
    wr(2'd2, 8'hFF);
    wait_cyc(40);
    chk(s_rx == 8'hB7, "R9 byte on wire kept", s_rx, 8'hB7);
    rd(2'd1, v); chk(v == 8'hC0, "R9 collision flag", v, 8'hC0);
    rd(2'd2, v); chk(v == 8'h24, "R9 read buffer", v, 8'h24);
    rd(2'd1, v); chk(v == 8'h00, "R9 collision cleared", v, 0);

    // R10: mode fault aborts
    wr(2'd0, 8'hCA);
    slave_prep(8'h00, 1, 0);
    wr(2'd2, 8'h81);
    wait_cyc(9);
    @(negedge clk); mf = 1; @(negedge clk); mf = 0;
    #1 chk(sck == 1, "R10 sck idle after abort", sck, 1);
    wait_cyc(40);
    chk(irq == 0, "R10 no completion", irq, 0);
    rd(2'd1, v); chk(v == 8'h10, "R10 fault flag", v, 8'h10);
    rd(2'd0, v); chk(v[6] == 0, "R10 master enable cleared", v, 8'h8A);
    wr(2'd0, 8'h48);
    rd(2'd1, v); chk(v == 8'h00, "R10 fault cleared", v, 0);

    // R6: interrupt masked
    slave_prep(8'h00, 1, 0);
    wr(2'd2, 8'h42);
    wait_cyc(40);
    chk(irq == 0, "R6 masked irq", irq, 0);
    rd(2'd1, v); chk(v == 8'h80, "R6 flag without irq", v, 8'h80);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule